// File: doc/BRIEF.md
# ADC Power-Mode and Sleep Sequencer

This block is the digital control shell that sits in front of a 12-bit analog-to-digital converter. It decides when the converter gets power and a running clock. It accepts or refuses start requests, and it captures the finished sample into a result buffer. It also follows what the CPU is doing. A conversion that uses the system clock is abandoned when the CPU sleeps, and it is also abandoned during CPU idle when the idle-stop control is set. A conversion that uses the dedicated RC clock waits one instruction period and then runs on through sleep. When it finishes, it raises an interrupt that can wake the CPU. If that interrupt is disabled, the block quietly cuts analog power until the CPU wakes, even though the enable control is still set.

Each time the converter is powered up, the block waits a programmable number of cycles for it to settle before it will accept a start. A conversion runs while the clock-enable output is high. The converter answers with a one-cycle done strobe and its data word. The result buffer is written only by a completed conversion. Reset, sleep and idle never modify it.

Top module: `adc_pwr_seq`

## Requirements
- R1: While `en` is 0, `apwr_en`, `aclk_en` and `busy` are all 0 one cycle later. Dropping `en` during a conversion aborts it without writing `result`.
- R2: Each time analog power comes up, the block counts STAB_CYC clock cycles before it accepts a start. A `start_req` seen in any earlier cycle is ignored, and `busy` stays 0.
- R3: With `rc_sel`=0, an accepted start raises `busy` and `aclk_en` on the next cycle. The conversion lasts until the done strobe is seen.
- R4: A done strobe seen while converting and not halted has three effects at the same edge. It writes `conv_data` into `result`, it clears `busy` and `aclk_en`, and it raises `irq_wake` for exactly one cycle when `irq_en`=1 (no pulse when `irq_en`=0).
- R5: A `start_req` that arrives while `busy` is 1 is ignored. The running conversion ends at its original time.
- R6: With `rc_sel`=0, `cpu_sleep`=1 aborts any pending or running conversion on the next cycle. `result` keeps its old value, and the conversion is not resumed when sleep ends.
- R7: With `rc_sel`=1, an accepted start holds `busy`=1 and `aclk_en`=0 for INSTR_CYC cycles, then raises `aclk_en`. The conversion continues through `cpu_sleep`=1.
- R8: A conversion that completes during sleep with `irq_en`=0 drives `apwr_en` to 0 while `en` stays 1. Power returns one cycle after `cpu_sleep` falls, and the R2 settling count restarts.
- R9: With `idle_stop`=1, `cpu_idle`=1 aborts a conversion like R6. With `idle_stop`=0, conversions complete normally during idle.
- R10: `rst` aborts any conversion and clears `busy`, `aclk_en`, `apwr_en` and `irq_wake`. `result` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable control |
| rc_sel | input | 1 | 1 selects the RC conversion clock, 0 the system clock |
| idle_stop | input | 1 | 1 halts the block during CPU idle |
| irq_en | input | 1 | Conversion-complete interrupt enable |
| cpu_sleep | input | 1 | CPU is in sleep |
| cpu_idle | input | 1 | CPU is in idle |
| start_req | input | 1 | Start-conversion request |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_data | input | DATA_W | Converter sample, valid with conv_done |
| busy | output | 1 | Conversion pending or running |
| result | output | DATA_W | Last completed sample |
| irq_wake | output | 1 | One-cycle interrupt / wake request |
| aclk_en | output | 1 | Converter clock enable |
| apwr_en | output | 1 | Converter power enable |

## Verification
The vector table runs one conversion under each combination that matters: clock source, sleep or idle entered just after the start, the idle-stop setting, and the interrupt enable. Each vector checks the buffer contents, the number of wake pulses and the analog power level. Together these tell a completed conversion from an aborted one, a wake from a silent power-down, and halting in idle from running through it. Directed cases then check the exact cycle counts of the settling hold-off and the RC start delay. They also cover a second start during a conversion, dropping the enable mid-conversion, and a reset that must leave the buffer as it was.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_stab.sv
// Settling counter: ready rises after STAB_CYC cycles without clr.
module adc_seq_stab #(
  parameter int STAB_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic ready
);
  generate
    if (STAB_CYC == 0) begin : g_nowait
      always_ff @(posedge clk) begin
        if (rst || clr) ready <= 1'b0;
        else            ready <= 1'b1;
      end
    end else begin : g_count
      localparam int CW = $clog2(STAB_CYC + 1);
      localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          cnt   <= '0;
          ready <= 1'b0;
        end else if (!ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) ready <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/adc_seq_dly.sv
// Start-delay counter: expired is high in the DLY_CYC-th cycle of run.
module adc_seq_dly #(
  parameter int DLY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  generate
    if (DLY_CYC <= 1) begin : g_short
      assign expired = run;
    end else begin : g_count
      localparam int CW = $clog2(DLY_CYC);
      localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
      end
      assign expired = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/adc_seq_rbuf.sv
// Result buffer: no reset, so its contents survive device reset.
module adc_seq_rbuf #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (we) dout <= din;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rc_sel,
  input  logic idle_stop,
  input  logic irq_en,
  input  logic cpu_sleep,
  input  logic cpu_idle,
  input  logic start_req,
  input  logic conv_done,
  input  logic ready,
  input  logic dly_exp,
  output seq_state_e state,
  output logic wr,
  output logic irq_q,
  output logic pdown_q,
  output logic apwr_q
);
  seq_state_e state_d;
  logic halt, accept, done_acc, pdown_d;

  assign halt     = !en || (cpu_sleep && !rc_sel) || (cpu_idle && idle_stop);
  assign accept   = (state == ST_IDLE) && start_req && ready && !halt && !pdown_q;
  assign done_acc = (state == ST_CONV) && !halt && conv_done;
  assign wr       = done_acc;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (accept) state_d = rc_sel ? ST_DLY : ST_CONV;
      ST_DLY: begin
        if (halt)         state_d = ST_IDLE;
        else if (dly_exp) state_d = ST_CONV;
      end
      ST_CONV: if (halt || conv_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pdown_d = pdown_q;
    if (!en || !cpu_sleep)                     pdown_d = 1'b0;
    else if (done_acc && !irq_en)              pdown_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      irq_q   <= 1'b0;
      pdown_q <= 1'b0;
      apwr_q  <= 1'b0;
    end else begin
      state   <= state_d;
      irq_q   <= done_acc && irq_en;
      pdown_q <= pdown_d;
      apwr_q  <= en && !pdown_d;
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int STAB_CYC = 8,
  parameter int INSTR_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rc_sel,
  input  logic              idle_stop,
  input  logic              irq_en,
  input  logic              cpu_sleep,
  input  logic              cpu_idle,
  input  logic              start_req,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              irq_wake,
  output logic              aclk_en,
  output logic              apwr_en
);
  seq_state_e state;
  logic ready, dly_exp, wr, pdown_q;

  adc_seq_stab #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk(clk), .rst(rst), .clr(!en || pdown_q), .ready(ready)
  );

  adc_seq_dly #(.DLY_CYC(INSTR_CYC)) u_dly (
    .clk(clk), .rst(rst), .run(state == ST_DLY), .expired(dly_exp)
  );

  adc_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en(en), .rc_sel(rc_sel), .idle_stop(idle_stop),
    .irq_en(irq_en), .cpu_sleep(cpu_sleep), .cpu_idle(cpu_idle),
    .start_req(start_req), .conv_done(conv_done), .ready(ready),
    .dly_exp(dly_exp), .state(state), .wr(wr), .irq_q(irq_wake),
    .pdown_q(pdown_q), .apwr_q(apwr_en)
  );

  adc_seq_rbuf #(.DATA_W(DATA_W)) u_rbuf (
    .clk(clk), .we(wr), .din(conv_data), .dout(result)
  );

  assign busy    = (state != ST_IDLE);
  assign aclk_en = (state == ST_CONV);
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              rc_sel,
  input logic              idle_stop,
  input logic              irq_en,
  input logic              cpu_sleep,
  input logic              cpu_idle,
  input logic              conv_done,
  input logic              busy,
  input logic [DATA_W-1:0] result,
  input logic              irq_wake,
  input logic              aclk_en,
  input logic              apwr_en
);
  logic wr_seen = 1'b0;
  always_ff @(posedge clk) begin
    if (aclk_en && conv_done) wr_seen <= 1'b1;
  end

  // R1
  off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy && !aclk_en && !apwr_en));

  // R3
  clk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    aclk_en |-> busy);

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_wake |=> !irq_wake);

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_wake |-> $past(aclk_en && conv_done && irq_en));

  // R6
  sleep_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_sleep && !rc_sel) |=> !busy);

  // R9
  idle_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_idle && idle_stop) |=> !busy);

  // R8
  pdown_chk: assert property (@(posedge clk) disable iff (rst)
    (aclk_en && conv_done && cpu_sleep && rc_sel && en && !irq_en &&
     !(cpu_idle && idle_stop)) |=> !apwr_en);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_seen && !(aclk_en && conv_done)) |=> $stable(result));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .rc_sel(rc_sel), .idle_stop(idle_stop),
  .irq_en(irq_en), .cpu_sleep(cpu_sleep), .cpu_idle(cpu_idle),
  .conv_done(conv_done), .busy(busy), .result(result), .irq_wake(irq_wake),
  .aclk_en(aclk_en), .apwr_en(apwr_en)
);

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;
  localparam int DW = 12;
  localparam int STAB = 8;
  localparam int DLY = 4;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, rc_sel = 0, idle_stop = 0, irq_en = 0;
  logic cpu_sleep = 0, cpu_idle = 0, start_req = 0;
  logic conv_done;
  logic [DW-1:0] conv_data = '0;
  logic busy, irq_wake, aclk_en, apwr_en;
  logic [DW-1:0] result;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  int stub_cnt = 0;

  always #5 clk = ~clk;

  adc_pwr_seq #(.DATA_W(DW), .STAB_CYC(STAB), .INSTR_CYC(DLY)) uut (
    .clk(clk), .rst(rst), .en(en), .rc_sel(rc_sel), .idle_stop(idle_stop),
    .irq_en(irq_en), .cpu_sleep(cpu_sleep), .cpu_idle(cpu_idle),
    .start_req(start_req), .conv_done(conv_done), .conv_data(conv_data),
    .busy(busy), .result(result), .irq_wake(irq_wake), .aclk_en(aclk_en),
    .apwr_en(apwr_en)
  );

  // converter stub: fixed latency while its clock is enabled
  always_ff @(posedge clk) begin
    if (!aclk_en) stub_cnt <= 0;
    else          stub_cnt <= stub_cnt + 1;
  end
  assign conv_done = aclk_en && (stub_cnt == LAT - 1);

  always @(negedge clk) if (irq_wake) wake_cnt++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    step(1);
    start_req = 1'b0;
  endtask

  task automatic power_up();
    en = 1'b0;
    step(1);
    en = 1'b1;
    step(STAB + 1);
  endtask

  // {rc_sel, sleep, idle, idle_stop, irq_en, data, exp_result, exp_wakes, exp_pwr}
  localparam int VW = 5 + DW + DW + 2;
  localparam logic [VW-1:0] VEC [8] = '{
    {5'b00000, 12'hA5A, 12'hA5A, 1'b0, 1'b1},  // R3 R4 plain conversion
    {5'b01000, 12'h111, 12'hA5A, 1'b0, 1'b1},  // R6 sysclk sleep abort
    {5'b11001, 12'h3C3, 12'h3C3, 1'b1, 1'b1},  // R7 RC in sleep, wake
    {5'b11000, 12'h0F0, 12'h0F0, 1'b0, 1'b0},  // R8 RC in sleep, power down
    {5'b00101, 12'h123, 12'h123, 1'b1, 1'b1},  // R9 idle, keep running
    {5'b00110, 12'h222, 12'h123, 1'b0, 1'b1},  // R9 idle, stop
    {5'b10110, 12'h333, 12'h123, 1'b0, 1'b1},  // R9 RC idle, stop
    {5'b00001, 12'hFFF, 12'hFFF, 1'b1, 1'b1}   // R4 irq outside sleep
  };

  initial begin : watchdog
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R10 / R1 reset state
    chk("R10 busy", busy, 0);
    chk("R10 aclk_en", aclk_en, 0);
    chk("R1 apwr_en", apwr_en, 0);
    chk("R10 irq_wake", irq_wake, 0);

    for (int i = 0; i < 8; i++) begin
      logic [VW-1:0] v;
      int w0;
      v = VEC[i];
      rc_sel = v[VW-1]; irq_en = v[VW-5]; idle_stop = v[VW-4];
      conv_data = v[VW-6 -: DW];
      power_up();
      pulse_start();
      cpu_sleep = v[VW-2];
      cpu_idle  = v[VW-3];
      w0 = wake_cnt;
      step(LAT + DLY + 3);
      chk("R4/R6/R7/R9 result", result, v[2 +: DW]);
      chk("R4/R8 wake count", wake_cnt - w0, v[1]);
      chk("R8 apwr_en", apwr_en, v[0]);
      chk("R4 busy cleared", busy, 0);
      cpu_sleep = 0; cpu_idle = 0;
      step(1);
      chk("R8 power restored", apwr_en, 1);
    end
    idle_stop = 0; irq_en = 0; rc_sel = 0;

    // R2: start before settling done is ignored
    en = 0; step(1); en = 1;
    step(STAB - 1);
    pulse_start();
    step(2);
    chk("R2 early start ignored", busy, 0);
    pulse_start();
    chk("R2 start after settle", busy, 1);
    chk("R3 aclk_en next cycle", aclk_en, 1);
    // R5: second start while busy does not restart
    step(1);
    pulse_start();
    step(LAT - 3);
    chk("R5 still busy", busy, 1);
    step(1);
    chk("R5 ends on time", busy, 0);

    // R7: RC start delay exact
    rc_sel = 1;
    pulse_start();
    step(DLY - 1);
    chk("R7 delay busy", busy, 1);
    chk("R7 no clock during delay", aclk_en, 0);
    step(1);
    chk("R7 clock after delay", aclk_en, 1);
    step(LAT);
    chk("R7 done", busy, 0);

    // R8: settling restarts after power-down wake
    irq_en = 0; conv_data = 12'h0AA;
    pulse_start(); cpu_sleep = 1;
    step(DLY + LAT + 2);
    chk("R8 powered down", apwr_en, 0);
    chk("R8 result", result, 12'h0AA);
    cpu_sleep = 0;
    step(1);
    pulse_start();
    step(1);
    chk("R8 settle restarted", busy, 0);

    // R1: dropping en aborts
    rc_sel = 0; conv_data = 12'h777;
    power_up();
    pulse_start();
    en = 0;
    step(1);
    chk("R1 busy off", busy, 0);
    chk("R1 aclk off", aclk_en, 0);
    chk("R1 pwr off", apwr_en, 0);
    step(LAT);
    chk("R1 result kept", result, 12'h0AA);

    // R10: reset mid-conversion keeps result
    power_up();
    pulse_start();
    step(2);
    rst = 1;
    step(1);
    rst = 0;
    chk("R10 reset aborts", busy, 0);
    chk("R10 reset pwr", apwr_en, 0);
    step(LAT);
    chk("R10 result kept", result, 12'h0AA);

    // R6: start refused while asleep on system clock
    power_up();
    cpu_sleep = 1;
    pulse_start();
    step(1);
    chk("R6 no start in sleep", busy, 0);
    cpu_sleep = 0;
    step(LAT + 2);
    chk("R6 no resume", result, 12'h0AA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule